// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block watches a host processor on behalf of a power-management controller. A counter runs on the controller's slow internal clock and must be serviced before it reaches a programmable limit. When service is missing, the block first issues a selectable primary action: an interrupt, a wake request or a device-reset request. If a second full period then passes with no service, it issues a separate secondary action. Service comes from exactly one of two sources. The software source is a write to a kick bit in the control register. The hardware source is any edge on a pin. The source that is not selected is ignored.

The control register can only be changed after a key value has been written to a separate key register. Writing any other value to the key register locks the control register again. A device-reset action returns the watchdog to its first stage, and the block counts how many resets it has requested. After seven unserviced resets, it stops requesting resets and escalates to the secondary action instead. Status flags record which stages have fired. The start-up sequencer, the interrupt controller and the pin routing are outside this block.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, the control register reads 0x080D. The key register is locked, and all action pulses, status flags and the retry count are zero.
- R2: Writing 0xA5C3 at address 1 unlocks the control register, and writing any other value at address 1 locks it. A write at address 0 while the register is locked changes nothing and does not service the counter.
- R3: The control register fields are enable (bit 0), pause (bit 1), sleep-enable (bit 2), source (bit 3), kick (bit 4), timeout select (bits 7:5), primary action (bits 9:8) and secondary action (bits 11:10). The first expiry is signalled 2^(4+select) clock cycles after the clock edge that serviced the counter.
- R4: The action code selects the output that pulses: 0 is interrupt (irqReq), 1 is wake (wakeReq), 2 is device reset (rstReq) and 3 is none. The first expiry uses the primary code.
- R5: With no service, a second full period after the primary action produces the secondary action. After a secondary action other than a reset, the counter stops until it is serviced.
- R6: Clearing the enable bit freezes the count. Setting the bit again resumes the count from the frozen value and does not restart it.
- R7: While the pause bit is set, the count is frozen. Clearing the bit resumes the count.
- R8: When sleepMode is high and sleep-enable is 0, the count is frozen. When sleep-enable is 1, the count runs during sleep as the enable bit directs.
- R9: With source = 1 (software), an unlocked control write with kick = 1 restarts the count and returns the block to the first stage. With source = 0, that write does not service the counter.
- R10: With source = 0 (hardware), either edge on hwKickPin restarts the count three clock edges later, after two synchroniser stages. With source = 1, pin edges are ignored.
- R11: A device-reset action returns the block to the first stage and increments retryCount. Once retryCount reaches 7, retryExhausted is high and a reset-coded expiry pulses nothing but advances the stage. A service clears retryCount.
- R12: primFired and secFired become set when the corresponding stage expires, and they stay set until reset.
- R13: Every action pulse lasts one cycle, and at most one action output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 selects the control register, 1 selects the key register |
| wrData | input | 16 | Write data |
| ctrlRd | output | 16 | Current control register contents; the kick bit reads 0 |
| unlocked | output | 1 | High while control writes are accepted |
| sleepMode | input | 1 | System is in the sleep state |
| hwKickPin | input | 1 | Asynchronous hardware service pin |
| rstReq | output | 1 | Device-reset request pulse |
| wakeReq | output | 1 | Wake request pulse |
| irqReq | output | 1 | Interrupt request pulse |
| primFired | output | 1 | Sticky flag: the primary stage has expired |
| secFired | output | 1 | Sticky flag: the secondary stage has expired |
| retryCount | output | 3 | Number of unserviced watchdog resets requested |
| retryExhausted | output | 1 | The retry limit has been reached |

## Verification
The embedded properties check on every cycle that locked writes leave the configuration untouched. They also check that a service clears the counter, that a frozen counter holds its value and that a running counter steps by exactly one. Finally, they check that the action outputs are one-hot and last a single cycle, and that the retry count increments with each reset request and never exceeds its limit. Exact expiry distances depend on history, so only the directed scenarios can show them. These include the power-of-two lengths at the selection extremes, the escalation from primary to secondary, and the resume-without-restart behaviour of enable, pause and sleep. The scenarios also cover the three-edge hardware service latency on both pin edges, the rejection of the source that is not selected, and the switch to the secondary action after the seventh reset.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

  typedef enum logic [1:0] {
    ACT_IRQ   = 2'b00,
    ACT_WAKE  = 2'b01,
    ACT_RESET = 2'b10,
    ACT_NONE  = 2'b11
  } wdogAct_e;

  typedef enum logic [1:0] {
    STG_WATCH = 2'b00,
    STG_PRIM  = 2'b01,
    STG_DONE  = 2'b10
  } wdogStage_e;

  typedef struct packed {
    logic       enable;
    logic       pause;
    logic       sleepEna;
    logic       kickSrc;
    logic [2:0] tsel;
    wdogAct_e   primAct;
    wdogAct_e   secAct;
  } wdogCfg_t;

  typedef struct packed {
    logic clear;
    logic advance;
  } dpStrobe_t;

  localparam int BIT_EN    = 0;
  localparam int BIT_PAUSE = 1;
  localparam int BIT_SLEEP = 2;
  localparam int BIT_SRC   = 3;
  localparam int BIT_KICK  = 4;
  localparam int TSEL_LO   = 5;
  localparam int PRIM_LO   = 8;
  localparam int SEC_LO    = 10;
  localparam int CFG_BITS  = 12;

  localparam wdogCfg_t CFG_DEFAULT = '{
    enable:   1'b1,
    pause:    1'b0,
    sleepEna: 1'b1,
    kickSrc:  1'b1,
    tsel:     3'd0,
    primAct:  ACT_IRQ,
    secAct:   ACT_RESET
  };

endpackage

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
  import esc_wdog_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'('hA5C3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output wdogCfg_t          cfg,
  output logic              swKickWr,
  output logic              unlocked,
  output logic [DATA_W-1:0] ctrlRd
);

  localparam int PAD_W = DATA_W - CFG_BITS;

  wdogCfg_t cfgQ;
  wdogCfg_t cfgNext;
  logic     unlockQ;
  logic     ctrlWr;
  logic     keyWr;

  assign ctrlWr = wrEn && !wrAddr && unlockQ;
  assign keyWr  = wrEn && wrAddr;

  always_comb begin
    cfgNext.enable   = wrData[BIT_EN];
    cfgNext.pause    = wrData[BIT_PAUSE];
    cfgNext.sleepEna = wrData[BIT_SLEEP];
    cfgNext.kickSrc  = wrData[BIT_SRC];
    cfgNext.tsel     = wrData[TSEL_LO +: 3];
    cfgNext.primAct  = wdogAct_e'(wrData[PRIM_LO +: 2]);
    cfgNext.secAct   = wdogAct_e'(wrData[SEC_LO +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgQ    <= CFG_DEFAULT;
      unlockQ <= 1'b0;
    end else begin
      if (keyWr) unlockQ <= (wrData == UNLOCK_KEY);
      if (ctrlWr) cfgQ <= cfgNext;
    end
  end

  assign cfg      = cfgQ;
  assign unlocked = unlockQ;
  assign swKickWr = ctrlWr && wrData[BIT_KICK];
  assign ctrlRd   = {{PAD_W{1'b0}}, cfgQ.secAct, cfgQ.primAct, cfgQ.tsel, 1'b0,
                     cfgQ.kickSrc, cfgQ.sleepEna, cfgQ.pause, cfgQ.enable};

  assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrAddr && !unlocked) |=> $stable(cfgQ));

endmodule

// File: rtl/esc_wdog_dp.sv
module esc_wdog_dp
  import esc_wdog_pkg::*;
#(
  parameter int BASE_LOG = 4,
  parameter int TSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobe,
  input  logic [TSEL_W-1:0] tsel,
  output logic              atLimit
);

  localparam int CNT_W = BASE_LOG + (1 << TSEL_W) - 1;

  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   lastVal;

  always_comb begin
    span    = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG + int'(tsel));
    lastVal = span - {{CNT_W{1'b0}}, 1'b1};
    atLimit = (count == lastVal[CNT_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= atLimit ? '0 : count + 1'b1;
    end
  end

  assert_kick_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (count == '0));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clear && !strobe.advance) |=> $stable(count));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !strobe.clear && !atLimit) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/esc_wdog_ctrl.sv
module esc_wdog_ctrl
  import esc_wdog_pkg::*;
#(
  parameter int MAX_TRIES = 7,
  parameter int RETRY_W   = $clog2(MAX_TRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdogCfg_t           cfg,
  input  logic               swKickWr,
  input  logic               sleepMode,
  input  logic               hwKickPin,
  input  logic               atLimit,
  output dpStrobe_t          strobe,
  output logic               rstReq,
  output logic               wakeReq,
  output logic               irqReq,
  output logic               primFired,
  output logic               secFired,
  output logic [RETRY_W-1:0] retryCount,
  output logic               retryExhausted
);

  localparam logic [RETRY_W-1:0] TRY_LIMIT = RETRY_W'(MAX_TRIES);

  logic [2:0]         pinSync;
  logic               pinEdge;
  logic               kick;
  logic               run;
  logic               expire;
  logic               doReset;
  wdogAct_e           curAct;
  wdogStage_e         stage;
  logic [RETRY_W-1:0] retryQ;

  assign pinEdge = pinSync[2] ^ pinSync[1];
  assign kick    = (cfg.kickSrc && swKickWr) || (!cfg.kickSrc && pinEdge);
  assign run     = cfg.enable && !cfg.pause && (!sleepMode || cfg.sleepEna)
                   && (stage != STG_DONE);
  assign expire  = run && atLimit && !kick;
  assign curAct  = (stage == STG_WATCH) ? cfg.primAct : cfg.secAct;
  assign retryExhausted = (retryQ == TRY_LIMIT);
  assign doReset = expire && (curAct == ACT_RESET) && !retryExhausted;

  assign strobe.clear   = kick;
  assign strobe.advance = run;
  assign retryCount     = retryQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinSync   <= '0;
      stage     <= STG_WATCH;
      retryQ    <= '0;
      rstReq    <= 1'b0;
      wakeReq   <= 1'b0;
      irqReq    <= 1'b0;
      primFired <= 1'b0;
      secFired  <= 1'b0;
    end else begin
      pinSync <= {pinSync[1:0], hwKickPin};
      rstReq  <= doReset;
      wakeReq <= expire && (curAct == ACT_WAKE);
      irqReq  <= expire && (curAct == ACT_IRQ);
      if (expire && stage == STG_WATCH) primFired <= 1'b1;
      if (expire && stage == STG_PRIM)  secFired  <= 1'b1;
      if (kick) begin
        stage  <= STG_WATCH;
        retryQ <= '0;
      end else if (expire) begin
        if (doReset) begin
          stage  <= STG_WATCH;
          retryQ <= retryQ + 1'b1;
        end else begin
          stage <= (stage == STG_WATCH) ? STG_PRIM : STG_DONE;
        end
      end
    end
  end

  assert_one_action_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rstReq, wakeReq, irqReq}));

  assert_irq_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq || wakeReq || rstReq) |=> !(irqReq || wakeReq || rstReq));

  assert_retry_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    retryCount <= TRY_LIMIT);

  assert_retry_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstReq) |-> (retryCount == $past(retryCount) + 1'b1));

endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import esc_wdog_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BASE_LOG  = 4,
  parameter int MAX_TRIES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ctrlRd,
  output logic              unlocked,
  input  logic              sleepMode,
  input  logic              hwKickPin,
  output logic              rstReq,
  output logic              wakeReq,
  output logic              irqReq,
  output logic              primFired,
  output logic              secFired,
  output logic [2:0]        retryCount,
  output logic              retryExhausted
);

  wdogCfg_t  cfg;
  dpStrobe_t strobe;
  logic      swKickWr;
  logic      atLimit;

  esc_wdog_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfg(cfg), .swKickWr(swKickWr), .unlocked(unlocked), .ctrlRd(ctrlRd)
  );

  esc_wdog_ctrl #(.MAX_TRIES(MAX_TRIES), .RETRY_W(3)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .swKickWr(swKickWr),
    .sleepMode(sleepMode), .hwKickPin(hwKickPin), .atLimit(atLimit),
    .strobe(strobe), .rstReq(rstReq), .wakeReq(wakeReq), .irqReq(irqReq),
    .primFired(primFired), .secFired(secFired), .retryCount(retryCount),
    .retryExhausted(retryExhausted)
  );

  esc_wdog_dp #(.BASE_LOG(BASE_LOG), .TSEL_W(3)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .tsel(cfg.tsel), .atLimit(atLimit)
  );

endmodule

// File: tb/esc_watchdog_bench.sv
module esc_watchdog_bench;

  logic        clk = 1'b0;
  logic        rst_n, wrEn, wrAddr, sleepMode, hwKickPin;
  logic [15:0] wrData;
  logic [15:0] ctrlRd;
  logic        unlocked, rstReq, wakeReq, irqReq, primFired, secFired, retryExhausted;
  logic [2:0]  retryCount;
  int          vectors = 0;
  int          miscompares = 0;

  localparam logic [15:0] KEY = 16'hA5C3;

  always #5 clk = ~clk;

  esc_watchdog u_esc_watchdog (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ctrlRd(ctrlRd), .unlocked(unlocked), .sleepMode(sleepMode), .hwKickPin(hwKickPin),
    .rstReq(rstReq), .wakeReq(wakeReq), .irqReq(irqReq), .primFired(primFired),
    .secFired(secFired), .retryCount(retryCount), .retryExhausted(retryExhausted)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCtrl(bit en, bit ps, bit se, bit src, bit kick,
                                         int tsel, int prim, int sec);
    return {4'b0, 2'(sec), 2'(prim), 3'(tsel), kick, src, se, ps, en};
  endfunction

  task automatic wr(bit a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0; wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
    sleepMode = 1'b0; hwKickPin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mask: 1 = irq, 2 = wake, 4 = reset; n = -1 when nothing pulses
  task automatic waitAny(int maxCyc, output int n, output int mask);
    n = -1; mask = 0;
    for (int i = 1; i <= maxCyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (rstReq || wakeReq || irqReq) begin
        n = i;
        mask = {29'b0, rstReq, wakeReq, irqReq};
        break;
      end
    end
  endtask

  task automatic testReset();
    doReset();
    chk("R1 ctrl default", int'(ctrlRd), 16'h080D);
    chk("R1 locked", int'(unlocked), 0);
    chk("R1 pulses low", int'({rstReq, wakeReq, irqReq}), 0);
    chk("R1 flags low", int'({primFired, secFired, retryExhausted}), 0);
    chk("R1 retry zero", int'(retryCount), 0);
  endtask

  task automatic testDefault();
    int n, m;
    doReset();
    waitAny(100, n, m);
    chk("R3 first expiry", n, 16);
    chk("R4 primary irq", m, 1);
    chk("R12 primFired", int'({primFired, secFired}), 2);
    waitAny(100, n, m);
    chk("R5 secondary delay", n, 16);
    chk("R5 secondary reset", m, 4);
    chk("R12 secFired", int'(secFired), 1);
    chk("R11 retry one", int'(retryCount), 1);
    waitAny(100, n, m);
    chk("R11 back to first stage", m, 1);
  endtask

  task automatic testLock();
    int n, m;
    doReset();
    wr(1'b0, mkCtrl(0, 0, 1, 1, 1, 0, 1, 1));
    chk("R2 locked write ignored", int'(ctrlRd), 16'h080D);
    waitAny(40, n, m);
    chk("R2 locked kick ignored", n, 15);
    wr(1'b1, KEY);
    chk("R2 key unlocks", int'(unlocked), 1);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 0, 5, 1, 3));
    chk("R2 unlocked write", int'(ctrlRd), int'(mkCtrl(1, 0, 1, 1, 0, 5, 1, 3)));
    wr(1'b1, 16'h1234);
    chk("R2 wrong key locks", int'(unlocked), 0);
    wr(1'b0, mkCtrl(0, 1, 0, 0, 0, 2, 2, 0));
    chk("R2 relocked write ignored", int'(ctrlRd), int'(mkCtrl(1, 0, 1, 1, 0, 5, 1, 3)));
  endtask

  task automatic testTsel();
    int n, m;
    doReset();
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 2, 0, 2));
    waitAny(200, n, m);
    chk("R3 select 2 length", n, 64);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 7, 1, 2));
    waitAny(3000, n, m);
    chk("R3 select 7 length", n, 2048);
    chk("R4 primary wake", m, 2);
  endtask

  task automatic testEnablePause(bit usePause);
    int n, m;
    doReset();
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 0, 2));
    if (usePause) wr(1'b0, mkCtrl(1, 1, 1, 1, 0, 0, 0, 2));
    else          wr(1'b0, mkCtrl(0, 0, 1, 1, 0, 0, 0, 2));
    waitAny(30, n, m);
    chk(usePause ? "R7 paused no expiry" : "R6 disabled no expiry", n, -1);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 0, 0, 0, 2));
    waitAny(40, n, m);
    chk(usePause ? "R7 resume keeps count" : "R6 enable keeps count", n, 15);
  endtask

  task automatic testSleep();
    int n, m;
    doReset();
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 0, 1, 1, 0, 0, 2));
    sleepMode = 1'b1;
    waitAny(30, n, m);
    chk("R8 sleep freezes", n, -1);
    sleepMode = 1'b0;
    waitAny(40, n, m);
    chk("R8 wake resumes", n, 16);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 0, 2));
    sleepMode = 1'b1;
    waitAny(40, n, m);
    chk("R8 sleep-enable runs", n, 16);
    sleepMode = 1'b0;
  endtask

  task automatic testKickSources();
    int n, m;
    doReset();
    repeat (9) @(negedge clk);
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 0, 2));
    waitAny(40, n, m);
    chk("R9 software kick restarts", n, 16);
    wr(1'b0, mkCtrl(1, 0, 1, 0, 0, 0, 0, 2));
    wr(1'b0, mkCtrl(1, 0, 1, 0, 1, 0, 0, 2));
    waitAny(40, n, m);
    chk("R9 software kick ignored in hw mode", n, 14);
    chk("R9 secondary after ignored kick", m, 4);
    hwKickPin = 1'b1;
    waitAny(40, n, m);
    chk("R10 rising pin kick", n, 19);
    chk("R10 rising kick to first stage", m, 1);
    hwKickPin = 1'b0;
    waitAny(40, n, m);
    chk("R10 falling pin kick", n, 19);
    chk("R10 falling kick to first stage", m, 1);
  endtask

  task automatic testPinIgnored();
    int n, m;
    doReset();
    hwKickPin = 1'b1;
    repeat (6) @(negedge clk);
    hwKickPin = 1'b0;
    waitAny(40, n, m);
    chk("R10 pin ignored in sw mode", n, 10);
  endtask

  task automatic testHalt();
    int n, m;
    doReset();
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 0, 1));
    waitAny(40, n, m);
    chk("R4 primary irq", m, 1);
    waitAny(40, n, m);
    chk("R5 secondary wake delay", n, 16);
    chk("R5 secondary wake", m, 2);
    waitAny(100, n, m);
    chk("R5 halted after secondary", n, -1);
    chk("R12 both flags held", int'({primFired, secFired}), 3);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 0, 1));
    waitAny(40, n, m);
    chk("R5 kick restarts after halt", n, 16);
    chk("R12 flags stay after kick", int'({primFired, secFired}), 3);
  endtask

  task automatic testRetry();
    int n, m;
    doReset();
    wr(1'b1, KEY);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 2, 1));
    for (int k = 1; k <= 7; k++) begin
      waitAny(40, n, m);
      chk("R11 reset period", n, 16);
      chk("R11 reset pulse", m, 4);
      chk("R11 retry count", int'(retryCount), k);
    end
    chk("R11 exhausted", int'(retryExhausted), 1);
    waitAny(60, n, m);
    chk("R11 escalates after limit", n, 32);
    chk("R11 secondary wake after limit", m, 2);
    wr(1'b0, mkCtrl(1, 0, 1, 1, 1, 0, 2, 1));
    chk("R11 kick clears retries", int'(retryCount), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL run-timeout: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    testReset();
    testDefault();
    testLock();
    testTsel();
    testEnablePause(1'b0);
    testEnablePause(1'b1);
    testSleep();
    testKickSources();
    testPinIgnored();
    testHalt();
    testRetry();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule